// File: doc/BRIEF.md
# Power-Good Strap Latch Sequencer

This block freezes the board's configuration straps exactly once during power-up. One input pin first carries an active-low power-good strobe. The first time the synchronized strobe is seen low, the block samples five strap pins: three frequency-select bits (C, B, A), a test-select bit and a debug-port-enable bit. From then on it holds those values. The same pin then becomes a live, active-high power-down request.

The frozen straps drive several outputs: a valid flag, the raw frequency code, a decoded CPU rate in MHz with a reserved-code flag, a test Hi-Z request, and a route select. The route select sends one shared differential pair either to a CPU function or to an SRC function. A configuration byte exposes the captured frequency bits for a register file. Until capture, every output is held low.

When the latched test-select bit is set, the one-shot rule is relaxed. Each new high-to-low transition of the pin re-captures all straps, and no power-down request is raised.

Top module: `pgs_strap_seq`

## Requirements
- R1: While reset is held, and after reset until capture, `straps_valid`, `freq_code`, `cpu_mhz`, `freq_reserved`, `test_hiz`, `pair_to_cpu`, `pd_req` and `cfg_byte` are all 0.
- R2: The pin passes through a two-flop synchronizer. If the pin is driven low before rising edge k, `straps_valid` is still 0 after edge k+1 and is 1 after edge k+2. The strap values present on the same cycle are then captured.
- R3: Once captured with test-select 0, later changes on the strap pins and on the pin itself leave `freq_code`, `cpu_mhz`, `test_hiz`, `pair_to_cpu` and `cfg_byte` unchanged until reset.
- R4: After capture with test-select 0, `pd_req` follows the pin with two cycles of latency: it is 1 when the pin is high and 0 when the pin is low. Before capture it is 0.
- R5: The captured debug-enable bit selects the route: 0 gives `pair_to_cpu`=0 (SRC function), and 1 gives `pair_to_cpu`=1 (CPU function).
- R6: `test_hiz` equals the captured test-select bit (1 = all outputs Hi-Z). While it is 1, `pd_req` stays 0.
- R7: While the captured test-select bit is 1, a high-to-low transition of the pin re-captures all five straps. The new values are visible after the third rising edge following the pin going low, and not after the second.
- R8: `cfg_byte[2]`, `[1]` and `[0]` hold the captured C, B and A bits, with 0 meaning that pin was low at capture. `cfg_byte[7:3]` is 0. `freq_code` is {C,B,A}.
- R9: `cpu_mhz` decodes `freq_code` (C is the MSB) as follows: 101→100, 001→133, 011→166, 010→200, 000→266. Codes 100, 110 and 111 are reserved: `freq_reserved`=1 and `cpu_mhz`=0.
- R10: A reset after capture returns the block to the pre-capture state, and a later low on the pin captures the straps anew.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pd_pin | input | 1 | Shared pin: power-good strobe (active low) before capture, power-down request (active high) after |
| fsel_c_pin | input | 1 | Frequency-select strap, bit C (MSB) |
| fsel_b_pin | input | 1 | Frequency-select strap, bit B |
| fsel_a_pin | input | 1 | Frequency-select strap, bit A (LSB) |
| test_sel_pin | input | 1 | Test-select strap |
| dbg_en_pin | input | 1 | Debug-port-enable strap |
| straps_valid | output | 1 | Straps have been captured |
| freq_code | output | 3 | Captured {C,B,A} |
| cpu_mhz | output | 9 | Decoded CPU rate in MHz, 0 if reserved or not captured |
| freq_reserved | output | 1 | Captured code is reserved |
| test_hiz | output | 1 | Request to place all outputs in Hi-Z |
| pair_to_cpu | output | 1 | Shared pair route: 1 = CPU function, 0 = SRC function |
| pd_req | output | 1 | Live power-down request |
| cfg_byte | output | 8 | Read-only strap byte for a register file |

## Verification
The bench sweeps all 32 strap combinations through a full reset-and-capture cycle. A decode table with a swapped entry, a bit-order error in the config byte, or an inverted route select would each show up as a mismatch on a specific code.

The capture cycle is probed one edge early and on time. A design that skipped a synchronizer flop would assert valid too soon, and one with an extra flop would assert it too late.

A strobe that is toggled after a normal-mode capture, while the straps change underneath it, catches a design that re-captures without the test-mode gate. Test mode is then entered and left through re-capture. A design that raised power-down during test mode, or ignored the falling transition, would fail there.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int RATE_W    = 9;
    localparam int FCODE_W   = 3;
    localparam int CFG_W     = 8;
    localparam int STRAP_W   = 5;

    typedef struct packed {
        logic fs_c;
        logic fs_b;
        logic fs_a;
        logic test_sel;
        logic dbg_en;
    } strap_t;

    typedef enum logic {
        CAP_WAIT   = 1'b0,
        CAP_LOCKED = 1'b1
    } cap_state_e;

    typedef struct packed {
        logic [RATE_W-1:0] mhz;
        logic              reserved;
    } rate_t;

    function automatic rate_t decode_rate(input logic [FCODE_W-1:0] code);
        rate_t r;
        r.reserved = 1'b0;
        unique case (code)
            3'b101:  r.mhz = RATE_W'(100);
            3'b001:  r.mhz = RATE_W'(133);
            3'b011:  r.mhz = RATE_W'(166);
            3'b010:  r.mhz = RATE_W'(200);
            3'b000:  r.mhz = RATE_W'(266);
            default: begin
                r.mhz      = '0;
                r.reserved = 1'b1;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("pgs_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[LAST];

endmodule

// File: rtl/pgs_capture.sv
module pgs_capture
    import pgs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pg_s,
    input  strap_t straps_s,
    output strap_t strap_q,
    output logic   locked,
    output logic   cap_pulse
);

    cap_state_e state;
    logic       pg_d;
    logic       pg_fall;
    logic       first_low;
    logic       test_recap;

    assign pg_fall    = pg_d & ~pg_s;
    assign first_low  = (state == CAP_WAIT) & ~pg_s;
    assign test_recap = (state == CAP_LOCKED) & strap_q.test_sel & pg_fall;
    assign cap_pulse  = first_low | test_recap;
    assign locked     = (state == CAP_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CAP_WAIT;
            strap_q <= '0;
            pg_d    <= 1'b1;
        end else begin
            pg_d <= pg_s;
            if (cap_pulse) begin
                strap_q <= straps_s;
                state   <= CAP_LOCKED;
            end
        end
    end

    // R2: the capture strobe never lasts more than one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        cap_pulse |=> !cap_pulse);

    // R3: outside test mode the latched straps are frozen
    a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
        (locked && !strap_q.test_sel) |=> $stable(strap_q));

    // R2: lock is only reached through a capture strobe
    a_r2_lock_from_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(cap_pulse));

    // R10: once locked, only reset leaves the locked state
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

endmodule

// File: rtl/pgs_rate_decode.sv
module pgs_rate_decode
    import pgs_pkg::*;
(
    input  logic               valid,
    input  logic [FCODE_W-1:0] code,
    output logic [RATE_W-1:0]  mhz,
    output logic               reserved
);

    rate_t r;

    always_comb begin
        r = decode_rate(code);
        if (!valid) r = '0;
    end

    assign mhz      = r.mhz;
    assign reserved = r.reserved;

    // R9: a non-reserved valid code always yields one of the listed rates
    always_comb begin
        if (valid && !reserved)
            a_r9_known_rate: assert (mhz == 100 || mhz == 133 || mhz == 166 ||
                                     mhz == 200 || mhz == 266);
    end

endmodule

// File: rtl/pgs_strap_seq.sv
module pgs_strap_seq
    import pgs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pg_pd_pin,
    input  logic                fsel_c_pin,
    input  logic                fsel_b_pin,
    input  logic                fsel_a_pin,
    input  logic                test_sel_pin,
    input  logic                dbg_en_pin,
    output logic                straps_valid,
    output logic [FCODE_W-1:0]  freq_code,
    output logic [RATE_W-1:0]   cpu_mhz,
    output logic                freq_reserved,
    output logic                test_hiz,
    output logic                pair_to_cpu,
    output logic                pd_req,
    output logic [CFG_W-1:0]    cfg_byte
);

    localparam int CFG_PAD = CFG_W - FCODE_W;

    logic   pg_s;
    strap_t straps_raw;
    strap_t straps_s;
    strap_t strap_q;
    logic   locked;
    logic   cap_pulse;

    assign straps_raw = '{fs_c: fsel_c_pin, fs_b: fsel_b_pin, fs_a: fsel_a_pin,
                          test_sel: test_sel_pin, dbg_en: dbg_en_pin};

    pgs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pg_sync (
        .clk (clk),
        .rst (rst),
        .d   (pg_pd_pin),
        .q   (pg_s)
    );

    pgs_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_strap_sync (
        .clk (clk),
        .rst (rst),
        .d   (straps_raw),
        .q   (straps_s)
    );

    pgs_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .pg_s      (pg_s),
        .straps_s  (straps_s),
        .strap_q   (strap_q),
        .locked    (locked),
        .cap_pulse (cap_pulse)
    );

    assign straps_valid = locked;
    assign freq_code    = locked ? {strap_q.fs_c, strap_q.fs_b, strap_q.fs_a} : '0;
    assign test_hiz     = locked & strap_q.test_sel;
    assign pair_to_cpu  = locked & strap_q.dbg_en;
    assign pd_req       = locked & ~strap_q.test_sel & pg_s;
    assign cfg_byte     = {{CFG_PAD{1'b0}}, freq_code};

    pgs_rate_decode u_decode (
        .valid    (locked),
        .code     (freq_code),
        .mhz      (cpu_mhz),
        .reserved (freq_reserved)
    );

    // R4: a power-down request only exists after capture
    a_r4_pd_after_lock: assert property (@(posedge clk) disable iff (rst)
        pd_req |-> straps_valid);

    // R6: test mode suppresses the power-down request
    a_r6_no_pd_in_test: assert property (@(posedge clk) disable iff (rst)
        test_hiz |-> !pd_req);

    // R1: nothing leaves the block before capture
    a_r1_quiet_before_lock: assert property (@(posedge clk) disable iff (rst)
        !straps_valid |-> (cfg_byte == '0 && !pair_to_cpu && !test_hiz && cpu_mhz == '0));

endmodule

// File: tb/pgs_strap_seq_bench.sv
module pgs_strap_seq_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       pin;
    logic [4:0] sv;   // {C,B,A,test,dbg}
    logic       valid, res, hiz, cpu, pd;
    logic [2:0] code;
    logic [8:0] mhz;
    logic [7:0] cfg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pgs_strap_seq u_pgs_strap_seq (
        .clk (clk), .rst (rst), .pg_pd_pin (pin),
        .fsel_c_pin (sv[4]), .fsel_b_pin (sv[3]), .fsel_a_pin (sv[2]),
        .test_sel_pin (sv[1]), .dbg_en_pin (sv[0]),
        .straps_valid (valid), .freq_code (code), .cpu_mhz (mhz),
        .freq_reserved (res), .test_hiz (hiz), .pair_to_cpu (cpu),
        .pd_req (pd), .cfg_byte (cfg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_rate(input logic [2:0] c);
        case (c)
            3'b101: return 100;
            3'b001: return 133;
            3'b011: return 166;
            3'b010: return 200;
            3'b000: return 266;
            default: return 0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; pin = 1'b1;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic check_all(input string req, input logic [4:0] s);
        chk({req, " valid"}, valid, 1);
        chk({req, " R8 code"}, code, s[4:2]);
        chk({req, " R8 cfg"}, cfg, {5'b0, s[4:2]});
        chk({req, " R9 mhz"}, mhz, exp_rate(s[4:2]));
        chk({req, " R9 reserved"}, res, (exp_rate(s[4:2]) == 0));
        chk({req, " R6 hiz"}, hiz, s[1]);
        chk({req, " R5 route"}, cpu, s[0]);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pin = 1'b1; sv = '0;
        // R1: reset state
        tick(2);
        chk("R1 valid in reset", valid, 0);
        chk("R1 cfg in reset", cfg, 0);
        chk("R1 pd in reset", pd, 0);
        rst = 1'b0;
        sv = 5'b11111;
        tick(4);
        chk("R1 valid before capture", valid, 0);
        chk("R1 hiz before capture", hiz, 0);
        chk("R1 route before capture", cpu, 0);
        chk("R4 pd before capture", pd, 0);
        chk("R1 mhz before capture", mhz, 0);

        // R2 R5 R6 R8 R9: sweep every strap combination
        for (int v = 0; v < 32; v++) begin
            do_reset();
            sv  = 5'(v);
            pin = 1'b0;
            tick(2);
            chk("R2 not valid after two edges", valid, 0);
            tick(1);
            check_all("R2 sweep", 5'(v));
            chk("R4 pd low while pin low", pd, 0);
        end

        // R3 R4: normal-mode capture, then toggle strobe and straps
        do_reset();
        sv = 5'b00100; pin = 1'b0;
        tick(3);
        check_all("R3 base", 5'b00100);
        sv = 5'b11011; pin = 1'b1;
        tick(1);
        chk("R4 pd latency one edge", pd, 0);
        tick(1);
        chk("R4 pd high", pd, 1);
        pin = 1'b0;
        tick(2);
        chk("R4 pd back low", pd, 0);
        pin = 1'b1; tick(3); pin = 1'b0; tick(3);
        check_all("R3 frozen", 5'b00100);

        // R6 R7: test mode, recapture on falling transition
        do_reset();
        sv = 5'b01110; pin = 1'b0;
        tick(3);
        check_all("R6 test capture", 5'b01110);
        pin = 1'b1;
        tick(3);
        chk("R6 no pd in test", pd, 0);
        sv = 5'b01011; pin = 1'b0;
        tick(2);
        check_all("R7 not yet recaptured", 5'b01110);
        tick(1);
        check_all("R7 recaptured", 5'b01011);
        pin = 1'b1; tick(3);
        sv = 5'b10100; pin = 1'b0;
        tick(3);
        check_all("R7 leave test", 5'b10100);
        sv = 5'b01011; pin = 1'b1; tick(3);
        chk("R4 pd after leaving test", pd, 1);
        pin = 1'b0; tick(3);
        check_all("R3 frozen after test exit", 5'b10100);

        // R10: reset after capture, then capture again
        @(negedge clk);
        rst = 1'b1; pin = 1'b1;
        tick(1);
        rst = 1'b0;
        tick(1);
        chk("R10 valid cleared", valid, 0);
        chk("R10 cfg cleared", cfg, 0);
        sv = 5'b00001; pin = 1'b0;
        tick(3);
        check_all("R10 recapture", 5'b00001);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule